// File: doc/BRIEF.md
# Parallel Port Register Access Sequencer

This block sits on the host side of a legacy parallel port and carries out single-register reads and writes to a disk-interface adapter on the far end of the cable. A request names an operation, a bank, a register index and, for writes, a byte. The block turns the request into a fixed series of data-line and control-line steps, holding each step for `HOLD_CYCLES` clocks. For a read, it samples the upper four status lines twice and joins the two nibbles into one byte.

Four operations exist: read, write, connect and disconnect. Connect saves the current data and control outputs and parks the control lines at the rest value. Disconnect sends a fixed address through the latch pattern and then puts back the saved outputs. `busy` is high from the accepted request up to and including the one-cycle `done` pulse.

The controller states are IDLE, ADDR, LATCH, RD_LO, RD_HI, RD_END, WR_DATA, WR_STROBE, CONNECT, RESTORE and DONE. Transitions:
- IDLE goes to CONNECT on a connect request, and to ADDR on any other request.
- ADDR goes to LATCH.
- After its seventh sub-step, LATCH goes to RD_LO for a read, to WR_DATA for a write, or to RESTORE for a disconnect.
- The read path runs RD_LO, RD_HI, RD_END, then DONE.
- The write path runs WR_DATA, then WR_STROBE for four sub-steps, then DONE.
- CONNECT and RESTORE each go to DONE.
- DONE always goes back to IDLE.

A step advances only when its hold count expires.

Top module: `pport_reg_seq`

## Requirements
- R1: After reset, control out is 0xC, data out is 0x00, `busy` is 0, `done` is 0 and `rd_data` is 0x00.
- R2: The address byte for read and write is the index plus 0x08 when `bank` is 0, or plus 0x10 when `bank` is 1. It is driven together with control 0x4 as the first step.
- R3: After the address step, the control lines step through 0xC, 0xE, 0xE, 0xC, 0x4, 0x4, 0x4 with the address still on the data lines.
- R4: A read then drives control 0x6, 0x4 and 0x4. The status nibble sampled at the end of the 0x6 step becomes `rd_data[3:0]`, and the nibble sampled at the end of the next step becomes `rd_data[7:4]`. `rd_data` is valid with `done` and held afterwards.
- R5: A write then places the write byte on the data lines with control 0x4. After that it steps control through 0x5, 0x7, 0x5 and 0x4 with the byte held.
- R6: Connect (op 2) saves the current data and control outputs and drives control 0x4 for one step, leaving data unchanged.
- R7: Disconnect (op 3) sends address 0x20 with control 0x4, then the latch pattern, then one step that restores the data and control saved at the last connect.
- R8: Every step holds its control and data values for exactly `HOLD_CYCLES` clocks.
- R9: `busy` rises the cycle after an accepted request and stays high through `done`. `done` is a one-cycle pulse in the cycle after the last step ends. Requests while `busy` is high have no effect on the outputs. Operation codes: 0 read, 1 write, 2 connect, 3 disconnect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 1 | Request strobe, accepted when idle |
| op | input | 2 | Operation: 0 read, 1 write, 2 connect, 3 disconnect |
| bank | input | 1 | 0 register file (offset 0x08), 1 command set (offset 0x10) |
| idx | input | IDX_W | Register index |
| wdata | input | 8 | Byte to write |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 8 | Assembled read byte |
| pp_data | output | 8 | Parallel port data lines |
| pp_ctrl | output | 4 | Parallel port control lines |
| pp_status | input | 4 | Upper four parallel port status lines |

## Verification
The assertions check the following on every cycle:
- `done` is a single-cycle pulse that only appears while `busy` is high.
- An accepted request raises `busy`.
- The port outputs stay frozen while idle without a request.
- The outputs never change in the middle of a hold window; an independent phase counter in the checker tracks the window.

Only the bench scenarios can show:
- the order of the control values in each sequence and the address arithmetic for every bank and index;
- the nibble join against known status patterns;
- that a disconnect restores what the latest connect saved;
- that a stray request during an operation leaves the trace untouched.

// File: rtl/pps_pkg.sv
package pps_pkg;

    typedef enum logic [1:0] {
        OP_READ       = 2'd0,
        OP_WRITE      = 2'd1,
        OP_CONNECT    = 2'd2,
        OP_DISCONNECT = 2'd3
    } pps_op_e;

    typedef enum logic [3:0] {
        S_IDLE, S_ADDR, S_LATCH, S_RD_LO, S_RD_HI, S_RD_END,
        S_WR_DATA, S_WR_STROBE, S_CONNECT, S_RESTORE, S_DONE
    } pps_state_e;

    localparam logic [3:0] CTRL_RESET = 4'hC;
    localparam logic [3:0] CTRL_REST  = 4'h4;
    localparam logic [3:0] CTRL_RD_LO = 4'h6;
    localparam logic [7:0] OFS_REGS   = 8'h08;
    localparam logic [7:0] OFS_CMDS   = 8'h10;
    localparam logic [7:0] ADDR_DISC  = 8'h20;
    localparam logic [2:0] LATCH_LAST = 3'd6;
    localparam logic [2:0] STRB_LAST  = 3'd3;

    // Control value for each sub-step of the address latch pattern.
    function automatic logic [3:0] latch_ctrl(input logic [2:0] n);
        unique case (n)
            3'd0, 3'd3: latch_ctrl = 4'hC;
            3'd1, 3'd2: latch_ctrl = 4'hE;
            default:    latch_ctrl = 4'h4;
        endcase
    endfunction

    // Control value for each sub-step of the write strobe.
    function automatic logic [3:0] strobe_ctrl(input logic [2:0] n);
        unique case (n)
            3'd0, 3'd2: strobe_ctrl = 4'h5;
            3'd1:       strobe_ctrl = 4'h7;
            default:    strobe_ctrl = 4'h4;
        endcase
    endfunction

endpackage

// File: rtl/pps_step_timer.sv
module pps_step_timer #(
    parameter int HOLD_CYCLES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    output logic step_end
);
    localparam int CW = (HOLD_CYCLES > 1) ? $clog2(HOLD_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(HOLD_CYCLES - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (!active || cnt_q == LAST)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end

    assign step_end = active && (cnt_q == LAST);
endmodule

// File: rtl/pps_nibble_join.sv
module pps_nibble_join (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cap_lo,
    input  logic       cap_hi,
    input  logic [3:0] nib_in,
    output logic [7:0] result
);
    logic [3:0] lo_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_q   <= '0;
            result <= '0;
        end else begin
            if (cap_lo) lo_q   <= nib_in;
            if (cap_hi) result <= {nib_in, lo_q};
        end
    end
endmodule

// File: rtl/pport_reg_seq.sv
module pport_reg_seq
    import pps_pkg::*;
#(
    parameter int HOLD_CYCLES = 2,
    parameter int IDX_W       = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic [1:0]       op,
    input  logic             bank,
    input  logic [IDX_W-1:0] idx,
    input  logic [7:0]       wdata,
    output logic             busy,
    output logic             done,
    output logic [7:0]       rd_data,
    output logic [7:0]       pp_data,
    output logic [3:0]       pp_ctrl,
    input  logic [3:0]       pp_status
);
    pps_state_e state_q, state_d;
    pps_op_e    op_q;
    logic [2:0] sub_q;
    logic [7:0] wdata_q, saved_data_q;
    logic [3:0] saved_ctrl_q;
    logic       step_end, active;
    logic [7:0] req_addr;

    assign req_addr = (bank ? OFS_CMDS : OFS_REGS) + 8'(idx);
    assign busy     = (state_q != S_IDLE);
    assign done     = (state_q == S_DONE);
    assign active   = busy && !done;

    pps_step_timer #(.HOLD_CYCLES(HOLD_CYCLES)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .active   (active),
        .step_end (step_end)
    );

    pps_nibble_join u_join (
        .clk    (clk),
        .rst_n  (rst_n),
        .cap_lo (state_q == S_RD_LO && step_end),
        .cap_hi (state_q == S_RD_HI && step_end),
        .nib_in (pp_status),
        .result (rd_data)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:      if (req) state_d = (pps_op_e'(op) == OP_CONNECT) ? S_CONNECT : S_ADDR;
            S_ADDR:      if (step_end) state_d = S_LATCH;
            S_LATCH:
                if (step_end && sub_q == LATCH_LAST) begin
                    unique case (op_q)
                        OP_READ:  state_d = S_RD_LO;
                        OP_WRITE: state_d = S_WR_DATA;
                        default:  state_d = S_RESTORE;
                    endcase
                end
            S_RD_LO:     if (step_end) state_d = S_RD_HI;
            S_RD_HI:     if (step_end) state_d = S_RD_END;
            S_RD_END:    if (step_end) state_d = S_DONE;
            S_WR_DATA:   if (step_end) state_d = S_WR_STROBE;
            S_WR_STROBE: if (step_end && sub_q == STRB_LAST) state_d = S_DONE;
            S_CONNECT:   if (step_end) state_d = S_DONE;
            S_RESTORE:   if (step_end) state_d = S_DONE;
            S_DONE:      state_d = S_IDLE;
            default:     state_d = S_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Port outputs and operation context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pp_ctrl      <= CTRL_RESET;
            pp_data      <= '0;
            saved_ctrl_q <= CTRL_RESET;
            saved_data_q <= '0;
            op_q         <= OP_READ;
            wdata_q      <= '0;
            sub_q        <= '0;
        end else begin
            unique case (state_q)
                S_IDLE:
                    if (req) begin
                        op_q    <= pps_op_e'(op);
                        wdata_q <= wdata;
                        sub_q   <= '0;
                        pp_ctrl <= CTRL_REST;
                        unique case (pps_op_e'(op))
                            OP_CONNECT: begin
                                saved_ctrl_q <= pp_ctrl;
                                saved_data_q <= pp_data;
                            end
                            OP_DISCONNECT: pp_data <= ADDR_DISC;
                            default:       pp_data <= req_addr;
                        endcase
                    end
                S_ADDR:
                    if (step_end) begin
                        pp_ctrl <= latch_ctrl(3'd0);
                        sub_q   <= '0;
                    end
                S_LATCH:
                    if (step_end) begin
                        if (sub_q != LATCH_LAST) begin
                            sub_q   <= sub_q + 3'd1;
                            pp_ctrl <= latch_ctrl(sub_q + 3'd1);
                        end else begin
                            unique case (op_q)
                                OP_READ:  pp_ctrl <= CTRL_RD_LO;
                                OP_WRITE: begin
                                    pp_ctrl <= CTRL_REST;
                                    pp_data <= wdata_q;
                                end
                                default: begin
                                    pp_ctrl <= saved_ctrl_q;
                                    pp_data <= saved_data_q;
                                end
                            endcase
                        end
                    end
                S_RD_LO:
                    if (step_end) pp_ctrl <= CTRL_REST;
                S_WR_DATA:
                    if (step_end) begin
                        pp_ctrl <= strobe_ctrl(3'd0);
                        sub_q   <= '0;
                    end
                S_WR_STROBE:
                    if (step_end && sub_q != STRB_LAST) begin
                        sub_q   <= sub_q + 3'd1;
                        pp_ctrl <= strobe_ctrl(sub_q + 3'd1);
                    end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/pps_checks.sv
module pps_checks #(
    parameter int HOLD_CYCLES = 2
) (
    input logic       clk,
    input logic       rst_n,
    input logic       req,
    input logic       busy,
    input logic       done,
    input logic [7:0] pp_data,
    input logic [3:0] pp_ctrl
);
    localparam int CW = (HOLD_CYCLES > 1) ? $clog2(HOLD_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(HOLD_CYCLES - 1);

    logic [CW-1:0] phase_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                        phase_q <= '0;
        else if (!busy || phase_q == LAST) phase_q <= '0;
        else                               phase_q <= phase_q + 1'b1;
    end

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);

    p_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && req) |=> busy);

    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !req) |=> (!busy && $stable(pp_ctrl) && $stable(pp_data)));

    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done && phase_q != LAST) |=> ($stable(pp_ctrl) && $stable(pp_data)));

endmodule

bind pport_reg_seq pps_checks #(.HOLD_CYCLES(HOLD_CYCLES)) u_checks (
    .clk     (clk),
    .rst_n   (rst_n),
    .req     (req),
    .busy    (busy),
    .done    (done),
    .pp_data (pp_data),
    .pp_ctrl (pp_ctrl)
);

// File: tb/tb_pport_reg_seq.sv
module tb_pport_reg_seq;
    localparam int H = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req = 1'b0;
    logic [1:0] op = 2'd0;
    logic       bank = 1'b0;
    logic [2:0] idx = 3'd0;
    logic [7:0] wdata = 8'd0;
    logic       busy, done;
    logic [7:0] rd_data, pp_data;
    logic [3:0] pp_ctrl, pp_status;
    logic [3:0] st_lo = 4'd0, st_hi = 4'd0;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    // Adapter model: first nibble while control is 0x6, second otherwise.
    assign pp_status = (pp_ctrl == 4'h6) ? st_lo : st_hi;

    pport_reg_seq #(.HOLD_CYCLES(H), .IDX_W(3)) dut (
        .clk(clk), .rst_n(rst_n), .req(req), .op(op), .bank(bank),
        .idx(idx), .wdata(wdata), .busy(busy), .done(done),
        .rd_data(rd_data), .pp_data(pp_data), .pp_ctrl(pp_ctrl),
        .pp_status(pp_status)
    );

    // Reference model state
    logic [3:0] m_ctrl = 4'hC, s_ctrl = 4'hC;
    logic [7:0] m_data = 8'h00, s_data = 8'h00;
    logic [3:0] e_ctrl [0:15];
    logic [7:0] e_data [0:15];
    int e_n;

    task automatic chk(input bit ok, input string rq, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    task automatic push(input logic [3:0] c, input logic [7:0] d);
        e_ctrl[e_n] = c;
        e_data[e_n] = d;
        e_n++;
    endtask

    task automatic push_latch(input logic [7:0] d);
        push(4'hC, d); push(4'hE, d); push(4'hE, d); push(4'hC, d);
        push(4'h4, d); push(4'h4, d); push(4'h4, d);
    endtask

    task automatic build(input logic [1:0] o, input logic b,
                         input logic [2:0] ix, input logic [7:0] wd);
        logic [7:0] a;
        a = (b ? 8'h10 : 8'h08) + {5'd0, ix};
        e_n = 0;
        case (o)
            2'd0: begin
                push(4'h4, a); push_latch(a);
                push(4'h6, a); push(4'h4, a); push(4'h4, a);
            end
            2'd1: begin
                push(4'h4, a); push_latch(a); push(4'h4, wd);
                push(4'h5, wd); push(4'h7, wd); push(4'h5, wd); push(4'h4, wd);
            end
            2'd2: begin
                s_ctrl = m_ctrl; s_data = m_data;
                push(4'h4, m_data);
            end
            default: begin
                push(4'h4, 8'h20); push_latch(8'h20); push(s_ctrl, s_data);
            end
        endcase
    endtask

    // Called at a falling edge; returns at a falling edge.
    task automatic do_op(input logic [1:0] o, input logic b, input logic [2:0] ix,
                         input logic [7:0] wd, input logic [3:0] lo,
                         input logic [3:0] hi, input bit stray, input string rq);
        int  bad_k;
        logic [3:0] bad_c;
        logic [7:0] bad_d;
        int  last;
        build(o, b, ix, wd);
        last = e_n * H;
        st_lo = lo; st_hi = hi;
        req = 1'b1; op = o; bank = b; idx = ix; wdata = wd;
        @(negedge clk);
        req = 1'b0;
        bad_k = -1; bad_c = '0; bad_d = '0;
        for (int k = 0; k <= last; k++) begin
            int s;
            if (stray && k == 1) begin req = 1'b1; op = 2'd2; idx = ~ix; end
            if (stray && k == 2) req = 1'b0;
            s = (k < last) ? k / H : e_n - 1;
            if (bad_k < 0 && (pp_ctrl !== e_ctrl[s] || pp_data !== e_data[s]
                              || busy !== 1'b1 || done !== (k == last))) begin
                bad_k = k; bad_c = pp_ctrl; bad_d = pp_data;
            end
            if (k == last && o == 2'd0)
                chk(rd_data === {hi, lo}, "R4", "read byte", rd_data, {hi, lo});
            if (bad_k < 0 || k < last) @(negedge clk);
            else @(negedge clk);
        end
        if (bad_k >= 0)
            chk(1'b0, rq, $sformatf("trace step %0d ctrl/data", bad_k),
                {bad_c, bad_d}, {e_ctrl[(bad_k < last) ? bad_k / H : e_n - 1],
                                 e_data[(bad_k < last) ? bad_k / H : e_n - 1]});
        else
            chk(1'b1, rq, "trace", 0, 0);
        m_ctrl = e_ctrl[e_n - 1];
        m_data = e_data[e_n - 1];
        chk(busy === 1'b0 && done === 1'b0 && pp_ctrl === m_ctrl && pp_data === m_data,
            "R9", "idle after done", {busy, done, pp_ctrl, pp_data},
            {2'b00, m_ctrl, m_data});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog R9 actual=%0h expected=%0h", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset values
        chk(pp_ctrl === 4'hC && pp_data === 8'h00, "R1", "port reset",
            {pp_ctrl, pp_data}, 12'hC00);
        chk(busy === 1'b0 && done === 1'b0 && rd_data === 8'h00, "R1", "status reset",
            {busy, done, rd_data}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R6: connect right after reset
        do_op(2'd2, 1'b0, 3'd0, 8'h00, 4'h0, 4'h0, 1'b0, "R6");

        // R2 R3 R4 R5 R8: sweep both banks and all indices
        for (int b = 0; b < 2; b++) begin
            for (int i = 0; i < 8; i++) begin
                logic [3:0] lo, hi;
                logic [7:0] wv;
                lo = 4'(i * 3 + b * 5 + 1);
                hi = 4'(15 - i) ^ {b[0], 3'b000};
                wv = 8'(i * 29 + b * 101 + 7);
                do_op(2'd0, b[0], 3'(i), 8'h00, lo, hi, 1'b0, "R2_R3_R4_R8");
                do_op(2'd1, b[0], 3'(i), wv, 4'h0, 4'h0, 1'b0, "R2_R3_R5_R8");
            end
        end

        // R9: request during an operation is ignored
        do_op(2'd0, 1'b1, 3'd5, 8'h00, 4'hA, 4'h3, 1'b1, "R9");
        repeat (2 * H) begin
            chk(busy === 1'b0 && done === 1'b0 && pp_ctrl === m_ctrl && pp_data === m_data,
                "R9", "no late action", {busy, done, pp_ctrl, pp_data},
                {2'b00, m_ctrl, m_data});
            @(negedge clk);
        end

        // R7: disconnect restores values saved after reset
        do_op(2'd3, 1'b0, 3'd0, 8'h00, 4'h0, 4'h0, 1'b0, "R7");

        // R6 R7: connect with non-trivial outputs, then write, then disconnect
        do_op(2'd0, 1'b0, 3'd6, 8'h00, 4'h1, 4'h2, 1'b0, "R4");
        do_op(2'd2, 1'b0, 3'd0, 8'h00, 4'h0, 4'h0, 1'b0, "R6");
        do_op(2'd1, 1'b1, 3'd2, 8'hC3, 4'h0, 4'h0, 1'b0, "R5");
        do_op(2'd3, 1'b0, 3'd0, 8'h00, 4'h0, 4'h0, 1'b0, "R7");
        chk(pp_data === 8'h0E && pp_ctrl === 4'h4, "R7", "restored outputs",
            {pp_ctrl, pp_data}, 12'h40E);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule